// File: doc/BRIEF.md
# Store Checking Filter for Snooped Dirty Reads

This block sits beside a processor core that runs in a redundant pair. It remembers the cache-block addresses of stores that no acknowledged execution signature covers yet. A snoop for a dirty block then asks the filter whether the block may hold unchecked data. If the answer is clear, the reply can go out at once. If the answer is "must check", the reply has to wait for the partner chip to confirm.

The address is cut into segments. Each segment is one-hot coded into its own field of a hash. Hashes are kept per signature interval:
- An active hash collects the current interval's stores.
- A FIFO of pending hashes holds intervals whose signature was sent but not yet acknowledged.
- An aggregate register is rebuilt every cycle as the OR of the active hash and all pending hashes. A lookup tests its own hash against this aggregate in a single step.

Store, signature-sent and acknowledge are plain one-cycle pulses. Snoop lookups use a valid/ready request channel and a valid/ready response channel. The response is held in a one-entry output register:
- A request is accepted when `snoop_ready` is high, and `snoop_ready` is high whenever the response register is empty or is being drained in that cycle.
- An unconsumed response holds its value and blocks new requests.

Top module: `store_chk_filter`

## Requirements
- R1: After reset the filter tracks nothing: every snoop reports clear (`rsp_must_check` 0), `sig_stall` is 0, `rsp_valid` is 0 and `snoop_ready` is 1.
- R2: A store accepted into the filter makes any later snoop of the same address report must-check until its interval is acknowledged; no tracked address ever reports clear.
- R3: The hash gives each 4-bit address segment its own 16-bit field and sets the bit indexed by the segment value. A snoop reports must-check exactly when every one of its segment bits is set by some tracked store, so mixing segments from two stores may report must-check, while a single segment value absent from all tracked stores reports clear.
- R4: A store is inserted only when its interval tag is newer than the acknowledge counter. Newer means that (tag minus counter) modulo 2^TAG_W lies in 1..DEPTH+1. Stores with a difference of 0 or above DEPTH+1 are ignored.
- R5: A signature-sent pulse pushes the active hash into the pending FIFO and starts an empty active hash; pushed addresses stay tracked.
- R6: An acknowledge removes only the oldest pending interval; younger pending intervals and the active hash stay tracked.
- R7: An acknowledge while the pending FIFO is empty has no effect: nothing is removed and the acknowledge counter does not advance.
- R8: A signature-sent pulse arriving while the FIFO holds DEPTH intervals, with no acknowledge in the same cycle, raises `sig_stall` in that same cycle and is dropped. The active hash keeps its contents.
- R9: When acknowledge, signature-sent and store fall in one cycle, they apply in the order pop, then push of the old active hash, then insertion of the store into the new active hash. The tag comparison uses the counter after the pop.
- R10: The acknowledge counter and tags are TAG_W bits wide and compared with wrap-around arithmetic.
- R11: A response appears on the cycle after its request is accepted. While `rsp_valid` is high and `rsp_ready` is low, the response holds and `snoop_ready` is low.
- R12: A lookup sees the filter state as it stood at the start of its acceptance cycle; a store in the same cycle is not visible to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | A store became globally visible this cycle |
| st_addr | input | SEG_W*NUM_SEG (32) | Cache-block address of the store |
| st_tag | input | TAG_W (7) | Signature interval tag of the store |
| sig_sent | input | 1 | A signature left for the partner this cycle |
| sig_ack | input | 1 | The partner acknowledged the oldest signature |
| sig_stall | output | 1 | Signature-sent dropped because the FIFO is full |
| snoop_valid | input | 1 | Lookup request valid |
| snoop_ready | output | 1 | Lookup request can be accepted |
| snoop_addr | input | SEG_W*NUM_SEG (32) | Cache-block address being snooped |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_ready | input | 1 | Consumer takes the lookup result |
| rsp_must_check | output | 1 | 1: reply must wait for a check; 0: reply directly |

## Verification
The bench builds the block with DEPTH=4, which makes TAG_W 3, and keeps the 8×4-bit segment layout. A full pending FIFO, the dropped signature that follows, and wrap of the acknowledge counter and tags are then reached within a few dozen events. With only eight tag values, both the too-old and the too-new sides of the window can be hit with small tags, and the triple coincidence of pop, push and insert can be placed right on a wrap.

// File: rtl/cfilt_pkg.sv
package cfilt_pkg;

  // Per-cycle operations decided by the control unit, applied in field order.
  typedef struct packed {
    logic pop;   // oldest pending interval retired
    logic push;  // active hash moved into the pending FIFO
    logic ins;   // store hash merged into the (new) active hash
  } cf_ops_t;

endpackage

// File: rtl/cf_hash_enc.sv
module cf_hash_enc #(
  parameter int SEG_W   = 4,
  parameter int NUM_SEG = 8,
  localparam int ADDR_W  = SEG_W * NUM_SEG,
  localparam int FIELD_W = 1 << SEG_W,
  localparam int HASH_W  = FIELD_W * NUM_SEG
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [HASH_W-1:0] hash
);

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    logic [SEG_W-1:0] seg_val;
    assign seg_val = addr[s*SEG_W +: SEG_W];
    assign hash[s*FIELD_W +: FIELD_W] = FIELD_W'(1) << seg_val;
  end

endmodule

// File: rtl/cf_pend_fifo.sv
module cf_pend_fifo #(
  parameter int HASH_W = 128,
  parameter int DEPTH  = 64,
  localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pop,
  input  logic              push,
  input  logic [HASH_W-1:0] push_hash,
  output logic              full,
  output logic              empty,
  output logic [CW-1:0]     count,
  output logic [HASH_W-1:0] or_next
);

  logic [HASH_W-1:0] mem_q [DEPTH];
  logic [DEPTH-1:0]  vld_q, vld_d;
  logic [PW-1:0]     head_q, tail_q;
  logic [CW-1:0]     cnt_q;

  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);
  assign count = cnt_q;

  // Next-state valid mask: the pop clears before the push sets.
  always_comb begin
    vld_d = vld_q;
    if (pop)  vld_d[head_q] = 1'b0;
    if (push) vld_d[tail_q] = 1'b1;
  end

  // OR of the entries that will be valid after this cycle's pop and push.
  always_comb begin
    or_next = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (vld_d[i]) begin
        if (push && (tail_q == PW'(i))) or_next = or_next | push_hash;
        else                           or_next = or_next | mem_q[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= '0;
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      vld_q <= vld_d;
      if (pop)  head_q <= head_q + PW'(1);
      if (push) tail_q <= tail_q + PW'(1);
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem_q[tail_q] <= push_hash;
  end

endmodule

// File: rtl/cf_ctrl.sv
module cf_ctrl
  import cfilt_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int TAG_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             st_valid,
  input  logic [TAG_W-1:0] st_tag,
  input  logic             sig_sent,
  input  logic             sig_ack,
  input  logic             fifo_full,
  input  logic             fifo_empty,
  output cf_ops_t          ops,
  output logic             stall,
  output logic [TAG_W-1:0] ack_cnt,
  output logic [TAG_W-1:0] tag_diff
);

  localparam logic [TAG_W-1:0] NEWEST = TAG_W'(DEPTH + 1);

  logic [TAG_W-1:0] ack_q, ack_eff;

  // Pop first: an acknowledge only counts if something is pending.
  assign ops.pop  = sig_ack && !fifo_empty;
  // Push second: a full FIFO has room if the pop freed a slot.
  assign ops.push = sig_sent && (!fifo_full || ops.pop);
  assign stall    = sig_sent && !ops.push;

  // Insert last, measured against the counter after the pop.
  assign ack_eff  = ack_q + TAG_W'(ops.pop);
  assign tag_diff = st_tag - ack_eff;
  assign ops.ins  = st_valid && (tag_diff != '0) && (tag_diff <= NEWEST);

  assign ack_cnt = ack_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_q <= '0;
    else        ack_q <= ack_eff;
  end

endmodule

// File: rtl/store_chk_filter.sv
module store_chk_filter
  import cfilt_pkg::*;
#(
  parameter int SEG_W   = 4,
  parameter int NUM_SEG = 8,
  parameter int DEPTH   = 64,
  parameter int TAG_W   = $clog2(DEPTH) + 1,
  parameter int ADDR_W  = SEG_W * NUM_SEG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [TAG_W-1:0]  st_tag,
  input  logic              sig_sent,
  input  logic              sig_ack,
  output logic              sig_stall,
  input  logic              snoop_valid,
  output logic              snoop_ready,
  input  logic [ADDR_W-1:0] snoop_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_must_check
);

  localparam int HASH_W = (1 << SEG_W) * NUM_SEG;
  localparam int CW     = $clog2(DEPTH + 1);

  cf_ops_t           ops;
  logic [HASH_W-1:0] st_hash, snoop_hash;
  logic [HASH_W-1:0] active_q, active_d, agg_q, pend_or;
  logic              fifo_full, fifo_empty;
  logic [CW-1:0]     fifo_cnt;
  logic [TAG_W-1:0]  ack_cnt, tag_diff;
  logic              snoop_take, snoop_hit;

  cf_hash_enc #(.SEG_W(SEG_W), .NUM_SEG(NUM_SEG)) i_st_enc (
    .addr(st_addr), .hash(st_hash)
  );

  cf_hash_enc #(.SEG_W(SEG_W), .NUM_SEG(NUM_SEG)) i_sn_enc (
    .addr(snoop_addr), .hash(snoop_hash)
  );

  cf_ctrl #(.DEPTH(DEPTH), .TAG_W(TAG_W)) i_ctrl (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_tag(st_tag),
    .sig_sent(sig_sent), .sig_ack(sig_ack),
    .fifo_full(fifo_full), .fifo_empty(fifo_empty),
    .ops(ops), .stall(sig_stall),
    .ack_cnt(ack_cnt), .tag_diff(tag_diff)
  );

  cf_pend_fifo #(.HASH_W(HASH_W), .DEPTH(DEPTH)) i_fifo (
    .clk(clk), .rst_n(rst_n),
    .pop(ops.pop), .push(ops.push), .push_hash(active_q),
    .full(fifo_full), .empty(fifo_empty), .count(fifo_cnt),
    .or_next(pend_or)
  );

  // Active hash: cleared by a push, then the store is merged in.
  always_comb begin
    active_d = ops.push ? '0 : active_q;
    if (ops.ins) active_d = active_d | st_hash;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= '0;
      agg_q    <= '0;
    end else begin
      active_q <= active_d;
      agg_q    <= pend_or | active_d;
    end
  end

  // Lookup against the aggregate as it stands at the start of the cycle.
  assign snoop_hit   = ((snoop_hash & agg_q) == snoop_hash);
  assign snoop_ready = !rsp_valid || rsp_ready;
  assign snoop_take  = snoop_valid && snoop_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid      <= 1'b0;
      rsp_must_check <= 1'b0;
    end else if (snoop_take) begin
      rsp_valid      <= 1'b1;
      rsp_must_check <= snoop_hit;
    end else if (rsp_ready) begin
      rsp_valid      <= 1'b0;
    end
  end

endmodule

// File: rtl/store_chk_filter_chk.sv
module store_chk_filter_chk #(
  parameter int HASH_W = 128,
  parameter int TAG_W  = 7,
  parameter int DEPTH  = 64,
  parameter int CW     = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sig_sent,
  input logic              sig_ack,
  input logic              sig_stall,
  input logic              st_valid,
  input logic              snoop_valid,
  input logic              snoop_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic              rsp_must_check,
  input logic [HASH_W-1:0] snoop_hash,
  input logic [HASH_W-1:0] active_q,
  input logic [HASH_W-1:0] agg_q,
  input logic              fifo_full,
  input logic              fifo_empty,
  input logic [CW-1:0]     fifo_cnt,
  input logic [TAG_W-1:0]  ack_cnt,
  input logic [TAG_W-1:0]  tag_diff,
  input logic              ins
);

  // R2: the aggregate always covers the active interval.
  assert_agg_covers_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((agg_q & active_q) == active_q));

  // R2: an accepted lookup fully inside the active hash reports must-check.
  assert_no_false_neg_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_valid && snoop_ready && ((snoop_hash & active_q) == snoop_hash)) |=> rsp_must_check);

  // R4: only newer tags are inserted.
  assert_ins_newer_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ins |-> (st_valid && tag_diff != '0));

  // R7: an acknowledge on an empty FIFO leaves the counter alone.
  assert_empty_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sig_ack && fifo_empty) |=> (ack_cnt == $past(ack_cnt)));

  // R8: stall only for a sent pulse into a full FIFO without an acknowledge.
  assert_stall_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sig_stall |-> (sig_sent && fifo_full && !sig_ack));

  // R8: occupancy never exceeds the depth.
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_cnt <= CW'(DEPTH)));

  // R11: a stalled response holds its value and blocks requests.
  assert_rsp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_must_check)));

  assert_req_block_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !snoop_ready);

endmodule

bind store_chk_filter store_chk_filter_chk #(
  .HASH_W((1 << SEG_W) * NUM_SEG), .TAG_W(TAG_W), .DEPTH(DEPTH), .CW($clog2(DEPTH + 1))
) i_chk (
  .clk(clk), .rst_n(rst_n), .sig_sent(sig_sent), .sig_ack(sig_ack),
  .sig_stall(sig_stall), .st_valid(st_valid), .snoop_valid(snoop_valid),
  .snoop_ready(snoop_ready), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_must_check(rsp_must_check), .snoop_hash(snoop_hash),
  .active_q(active_q), .agg_q(agg_q), .fifo_full(fifo_full),
  .fifo_empty(fifo_empty), .fifo_cnt(fifo_cnt), .ack_cnt(ack_cnt),
  .tag_diff(tag_diff), .ins(ops.ins)
);

// File: tb/test_store_chk_filter.sv
module test_store_chk_filter;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;
  localparam int TAG_W = $clog2(DEPTH) + 1;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic st_valid = 1'b0;
  logic [AW-1:0] st_addr = '0;
  logic [TAG_W-1:0] st_tag = '0;
  logic sig_sent = 1'b0, sig_ack = 1'b0, sig_stall;
  logic snoop_valid = 1'b0, snoop_ready;
  logic [AW-1:0] snoop_addr = '0;
  logic rsp_valid, rsp_ready = 1'b1, rsp_must_check;

  int n_checks = 0;
  int n_fail = 0;
  bit exp_q[$];
  string name_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  store_chk_filter #(.SEG_W(4), .NUM_SEG(8), .DEPTH(DEPTH)) i_store_chk_filter (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_addr(st_addr),
    .st_tag(st_tag), .sig_sent(sig_sent), .sig_ack(sig_ack),
    .sig_stall(sig_stall), .snoop_valid(snoop_valid),
    .snoop_ready(snoop_ready), .snoop_addr(snoop_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_must_check(rsp_must_check)
  );

  task automatic check(bit ok, string req, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  // Monitor: compares every delivered response with the scoreboard head.
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R11 unexpected response", 1, 0);
      end else begin
        bit e;
        string nm;
        e = exp_q.pop_front();
        nm = name_q.pop_front();
        check(rsp_must_check == e, nm, rsp_must_check, e);
      end
    end
  end

  // One cycle of events, driven at a falling edge.
  task automatic step(bit st, logic [AW-1:0] a, int tag, bit snd, bit ack);
    st_valid = st; st_addr = a; st_tag = TAG_W'(tag);
    sig_sent = snd; sig_ack = ack;
    @(negedge clk);
    st_valid = 1'b0; sig_sent = 1'b0; sig_ack = 1'b0;
  endtask

  // Driver: queue the expectation, then offer the request until taken.
  task automatic snoop(logic [AW-1:0] a, bit exp, string nm);
    bit ok;
    exp_q.push_back(exp);
    name_q.push_back(nm);
    snoop_valid = 1'b1; snoop_addr = a;
    do begin
      ok = snoop_ready;
      @(posedge clk);
    end while (!ok);
    @(negedge clk);
    snoop_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  localparam logic [AW-1:0] A = 32'h1234_5678, B = 32'h0000_0009;
  localparam logic [AW-1:0] C = 32'hAAAA_AAAA, D = 32'hCCCC_CCCC;
  localparam logic [AW-1:0] E = 32'hEEEE_EEEE, F = 32'hFFFF_FFFF;
  localparam logic [AW-1:0] G = 32'hDDDD_DDDD, H = 32'hBBBB_BBBB;
  localparam logic [AW-1:0] I = 32'h3333_3333, J = 32'h4444_4444;

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(sig_stall == 1'b0, "R1 stall after reset", sig_stall, 0);
    check(rsp_valid == 1'b0, "R1 rsp_valid after reset", rsp_valid, 0);
    check(snoop_ready == 1'b1, "R1 snoop_ready after reset", snoop_ready, 1);
    snoop(A, 1'b0, "R1 empty filter reports clear");
    drain();

    // R2 / R3: tag 1 is newer than counter 0
    step(1, A, 1, 0, 0);
    snoop(A, 1'b1, "R2 stored address must check");
    snoop(32'h1234_5679, 1'b0, "R3 absent segment value is clear");
    step(1, B, 1, 0, 0);
    snoop(32'h1234_5679, 1'b1, "R3 mixed segments false positive");
    snoop(32'h1234_5670, 1'b0, "R3 segment 0 value 0 not tracked");
    // R4: diff 0 and diff 6 are outside 1..5
    step(1, C, 0, 0, 0);
    step(1, C, 6, 0, 0);
    snoop(C, 1'b0, "R4 stale tags ignored");
    drain();

    // R5: push interval 1, open interval 2
    step(0, '0, 0, 1, 0);
    snoop(A, 1'b1, "R5 pushed address still tracked");
    step(1, D, 2, 0, 0);
    step(0, '0, 0, 1, 0);
    snoop(D, 1'b1, "R5 second interval tracked");
    drain();

    // R6: retire oldest only
    step(0, '0, 0, 0, 1);
    snoop(A, 1'b0, "R6 oldest interval retired");
    snoop(D, 1'b1, "R6 younger interval kept");
    step(0, '0, 0, 0, 1);
    snoop(D, 1'b0, "R6 second interval retired");
    drain();

    // R7: ack on empty FIFO; counter must stay 2, so tag 3 is newer
    step(0, '0, 0, 0, 1);
    step(1, E, 3, 0, 0);
    snoop(E, 1'b1, "R7 empty ack did not advance counter");
    drain();

    // R8: fill the FIFO with intervals 3..6
    for (int k = 0; k < DEPTH; k++) step(0, '0, 0, 1, 0);
    step(1, F, 7, 0, 0);
    sig_sent = 1'b1;
    #1;
    check(sig_stall == 1'b1, "R8 stall on full FIFO", sig_stall, 1);
    @(negedge clk);
    sig_sent = 1'b0;
    #1;
    check(sig_stall == 1'b0, "R8 stall drops after pulse", sig_stall, 0);
    snoop(F, 1'b1, "R8 active kept after dropped send");
    for (int k = 0; k < DEPTH; k++) step(0, '0, 0, 0, 1);
    snoop(E, 1'b0, "R8 pending intervals retired");
    snoop(F, 1'b1, "R8 active survives all acks");
    drain();

    // R9 + R10: push F as interval 7, then ack+send+store on a wrap
    step(0, '0, 0, 1, 0);
    step(1, G, 0, 1, 1);
    snoop(F, 1'b0, "R9 pop applied first");
    snoop(G, 1'b1, "R9 store accepted against popped counter");
    step(0, '0, 0, 0, 1);
    snoop(G, 1'b1, "R9 store landed in new active hash");
    drain();

    // R10: counter wrapped to 0
    step(1, H, 1, 0, 0);
    snoop(H, 1'b1, "R10 tag 1 newer after wrap");
    step(1, I, 0, 0, 0);
    step(1, I, 7, 0, 0);
    snoop(I, 1'b0, "R10 tags 0 and 7 stale after wrap");
    drain();

    // R12: lookup in the same cycle as the store sees the old state
    exp_q.push_back(1'b0);
    name_q.push_back("R12 same-cycle store not visible");
    st_valid = 1'b1; st_addr = J; st_tag = TAG_W'(1);
    snoop_valid = 1'b1; snoop_addr = J;
    @(negedge clk);
    st_valid = 1'b0; snoop_valid = 1'b0;
    snoop(J, 1'b1, "R12 store visible next cycle");
    drain();

    // R11: back-pressure on the response
    rsp_ready = 1'b0;
    snoop(J, 1'b1, "R11 held response value");
    check(rsp_valid == 1'b1, "R11 response valid while held", rsp_valid, 1);
    check(snoop_ready == 1'b0, "R11 request blocked", snoop_ready, 0);
    @(negedge clk);
    check(rsp_valid == 1'b1, "R11 response still held", rsp_valid, 1);
    check(snoop_ready == 1'b0, "R11 request still blocked", snoop_ready, 0);
    rsp_ready = 1'b1;
    drain();
    @(negedge clk);
    check(rsp_valid == 1'b0, "R11 response cleared after transfer", rsp_valid, 0);

    summary();
  end

endmodule